// File: doc/BRIEF.md
# SPI Configuration Load Sequencer

This controller runs a complete configuration session against a target device that accepts its configuration image through a slave SPI port. It never shifts bits itself. Instead it hands one byte at a time to a byte-oriented SPI master, together with a flag that says whether chip select must stay asserted after that byte. Before every command it obtains the device status through a separate poll handshake. It takes image bytes from a ready/valid stream.

A session is started by a one-cycle strobe. The sequencer first enables configuration mode on the device and reads back a four-byte acknowledgement, which must be all zero. It then places the device in program mode and sends the image as 16-byte frames, each frame opened by its own opcode. Finally it leaves configuration mode, waits a timed pause and releases the device. Any failed step parks the sequencer in a silent error state until the next start. The `operating` output reports whether the device can be treated as running user logic: no program session is open and the last status byte read was zero.

Top module: `spi_cfg_loader`

## Requirements
- R1: On `start`, the session is refused if `partial_req` is 1 or if `img_len` is not a multiple of 16. A refused session raises `err` with no poll and no SPI request.
- R2: Each command (all steps except the reply reads, the program-mode argument and the frame bytes) is preceded by status polls. Status bit 0 (busy) causes another poll. Bit 2 or bit 3 set raises `err`. Once MAX_POLLS polls for one command have answered busy or not-ready, `err` is raised.
- R3: The session opens with 0x0B in a window of its own (`spi_keep`=0). Polls follow until status bit 1 (ready) is set. Then 0x01 with `spi_keep`=1 is sent, followed by four fill bytes 0x00 whose replies on `spi_rx` are collected; `spi_keep` is 0 only on the fourth.
- R4: If any of the four collected reply bytes is nonzero, `err` is raised and no further poll, SPI request or image fetch follows.
- R5: Program mode is entered with 0xAE (`spi_keep`=1) followed at once by 0x01 (`spi_keep`=0).
- R6: Each frame is 0xEE (`spi_keep`=1) followed by 16 image bytes in stream order, with `spi_keep`=1 on all but the last. There are `img_len`/16 frames, and zero frames is legal.
- R7: After the frames, 0x0C (`spi_keep`=0) is sent. No poll starts for at least PAUSE_US microseconds, that is (CLK_HZ/1e6)*PAUSE_US cycles. Then 0x23 (`spi_keep`=0) is sent and `done` rises.
- R8: `operating` is 1 exactly when no program session is open and the last polled status byte is zero. A session opens on the program-mode argument and closes on the release byte; the status register resets to zero.
- R9: `done` and `err` are never both 1, and each holds until the next accepted `start`. A `start` during a running session is ignored.
- R10: `spi_req` stays high with stable `spi_tx` and `spi_keep` until `spi_ack`. `spi_req` and `poll_req` are never high together.
- R11: `img_ready` is high only while fetching a frame byte. Exactly one image byte is consumed per data byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Session start strobe |
| partial_req | input | 1 | Partial reconfiguration requested (refused) |
| img_len | input | LEN_W | Image payload length in bytes |
| img_valid | input | 1 | Image byte valid |
| img_data | input | 8 | Image byte |
| img_ready | output | 1 | Image byte accepted when valid |
| poll_req | output | 1 | Status poll request |
| poll_ack | input | 1 | Status poll answered |
| poll_status | input | 8 | Status byte, valid with poll_ack |
| spi_req | output | 1 | SPI byte transfer request |
| spi_tx | output | 8 | Byte to transmit |
| spi_keep | output | 1 | Keep chip select asserted after this byte |
| spi_ack | input | 1 | SPI byte transfer completed |
| spi_rx | input | 8 | Byte received during the transfer, valid with spi_ack |
| done | output | 1 | Session finished successfully |
| err | output | 1 | Session aborted |
| operating | output | 1 | Device considered operating (1) or unknown (0) |

## Verification
On every cycle, the assertions enforce the channel rules: one request channel active at a time, requests held stable until acknowledged, silence in the error state and during image fetches, `done` and `err` exclusive and sticky, and no poll inside the pause after 0x0C. The exact opcode order, the chip-select framing, the frame contents, the all-zero reply check, the retry limit, the length and partial-request rejection, and the `operating` transitions only show up in the bench's scenarios. There, a queue of expected bytes is compared against every SPI request as the responder models answer the polls and transfers.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int FRAME_BYTES = 16;
    localparam int REPLY_BYTES = 4;

    localparam logic [7:0] OP_CFG_ON   = 8'h0B;
    localparam logic [7:0] OP_QUERY    = 8'h01;
    localparam logic [7:0] OP_FILL     = 8'h00;
    localparam logic [7:0] OP_MODE     = 8'hAE;
    localparam logic [7:0] OP_MODE_ARG = 8'h01;
    localparam logic [7:0] OP_FRAME    = 8'hEE;
    localparam logic [7:0] OP_CFG_OFF  = 8'h0C;
    localparam logic [7:0] OP_RELEASE  = 8'h23;

    localparam int SB_BUSY  = 0;
    localparam int SB_READY = 1;
    localparam int SB_VIOL  = 2;
    localparam int SB_FAULT = 3;

    typedef enum logic [2:0] {
        PH_IDLE, PH_POLL, PH_XFER, PH_FETCH, PH_PAUSE, PH_DONE, PH_FAIL
    } phase_e;

    typedef enum logic [3:0] {
        SP_CFG_ON, SP_QUERY, SP_REPLY, SP_MODE, SP_MODE_ARG,
        SP_FRAME, SP_DATA, SP_CFG_OFF, SP_RELEASE
    } step_e;

    typedef struct packed {
        logic [7:0] op;
        logic       keep;
    } cmd_t;

    function automatic cmd_t step_cmd(step_e s, logic last);
        cmd_t c;
        c.keep = 1'b0;
        case (s)
            SP_CFG_ON:   c.op = OP_CFG_ON;
            SP_QUERY:    begin c.op = OP_QUERY; c.keep = 1'b1; end
            SP_REPLY:    begin c.op = OP_FILL;  c.keep = !last; end
            SP_MODE:     begin c.op = OP_MODE;  c.keep = 1'b1; end
            SP_MODE_ARG: c.op = OP_MODE_ARG;
            SP_FRAME:    begin c.op = OP_FRAME; c.keep = 1'b1; end
            SP_DATA:     begin c.op = OP_FILL;  c.keep = !last; end
            SP_CFG_OFF:  c.op = OP_CFG_OFF;
            default:     c.op = OP_RELEASE;
        endcase
        return c;
    endfunction

    function automatic logic step_polls(step_e s);
        return (s == SP_CFG_ON) || (s == SP_QUERY) || (s == SP_MODE) ||
               (s == SP_FRAME) || (s == SP_CFG_OFF) || (s == SP_RELEASE);
    endfunction

endpackage

// File: rtl/scl_poller.sv
module scl_poller #(
    parameter int MAX_POLLS = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       want_ready,
    input  logic       poll_ack,
    input  logic [7:0] poll_status,
    output logic       poll_req,
    output logic       pass,
    output logic       fail,
    output logic [7:0] last_status
);
    import scl_pkg::*;

    localparam int TW = $clog2(MAX_POLLS + 1);

    logic [TW-1:0] tries;
    logic hit, bad, again, spent;

    always_comb begin
        poll_req = arm;
        hit      = arm && poll_ack;
        bad      = poll_status[SB_VIOL] || poll_status[SB_FAULT];
        again    = poll_status[SB_BUSY] || (want_ready && !poll_status[SB_READY]);
        spent    = (tries == TW'(MAX_POLLS - 1));
        pass     = hit && !bad && !again;
        fail     = hit && (bad || (again && spent));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tries       <= '0;
            last_status <= '0;
        end else begin
            if (!arm)
                tries <= '0;
            else if (hit && again && !spent)
                tries <= tries + 1'b1;
            if (hit)
                last_status <= poll_status;
        end
    end
endmodule

// File: rtl/scl_pause.sv
module scl_pause #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left;
    logic          running;

    assign expired = running && (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left    <= '0;
            running <= 1'b0;
        end else if (load) begin
            left    <= CW'(CYCLES);
            running <= 1'b1;
        end else if (running) begin
            if (left == '0)
                running <= 1'b0;
            else
                left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader #(
    parameter int CLK_HZ    = 125_000_000,
    parameter int PAUSE_US  = 1500,
    parameter int MAX_POLLS = 10000,
    parameter int LEN_W     = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             partial_req,
    input  logic [LEN_W-1:0] img_len,
    input  logic             img_valid,
    input  logic [7:0]       img_data,
    output logic             img_ready,
    output logic             poll_req,
    input  logic             poll_ack,
    input  logic [7:0]       poll_status,
    output logic             spi_req,
    output logic [7:0]       spi_tx,
    output logic             spi_keep,
    input  logic             spi_ack,
    input  logic [7:0]       spi_rx,
    output logic             done,
    output logic             err,
    output logic             operating
);
    import scl_pkg::*;

    localparam int PAUSE_CYC = (CLK_HZ / 1_000_000) * PAUSE_US;
    localparam int FRM_LG    = $clog2(FRAME_BYTES);
    localparam int FCNT_W    = LEN_W - FRM_LG;
    localparam int CNT_W     = $clog2(FRAME_BYTES);

    phase_e            phase;
    step_e             step;
    logic [CNT_W-1:0]  cnt;
    logic [FCNT_W-1:0] frames_left;
    logic [7:0]        acc, data_q, last_status;
    logic              prog_q, done_q, err_q;
    logic              last, poll_pass, poll_fail, pause_load, pause_done;
    logic [7:0]        reply_or;
    cmd_t              cmd;

    always_comb begin
        last     = (step == SP_REPLY) ? (cnt == CNT_W'(REPLY_BYTES - 1))
                                      : (cnt == CNT_W'(FRAME_BYTES - 1));
        cmd      = step_cmd(step, last);
        spi_req  = (phase == PH_XFER);
        spi_tx   = (step == SP_DATA) ? data_q : cmd.op;
        spi_keep = cmd.keep;
        img_ready  = (phase == PH_FETCH);
        pause_load = spi_req && spi_ack && (step == SP_CFG_OFF);
        reply_or   = acc | spi_rx;
    end

    scl_poller #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk(clk), .rst(rst),
        .arm(phase == PH_POLL), .want_ready(step == SP_QUERY),
        .poll_ack(poll_ack), .poll_status(poll_status),
        .poll_req(poll_req), .pass(poll_pass), .fail(poll_fail),
        .last_status(last_status)
    );

    scl_pause #(.CYCLES(PAUSE_CYC)) u_pause (
        .clk(clk), .rst(rst), .load(pause_load), .expired(pause_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            step        <= SP_CFG_ON;
            cnt         <= '0;
            frames_left <= '0;
            acc         <= '0;
            data_q      <= '0;
            prog_q      <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE, PH_FAIL: if (start) begin
                    done_q <= 1'b0;
                    err_q  <= 1'b0;
                    step   <= SP_CFG_ON;
                    cnt    <= '0;
                    if (partial_req || (img_len[FRM_LG-1:0] != '0)) begin
                        phase <= PH_FAIL;
                        err_q <= 1'b1;
                    end else begin
                        phase       <= PH_POLL;
                        frames_left <= img_len[LEN_W-1:FRM_LG];
                    end
                end
                PH_POLL: begin
                    if (poll_fail) begin
                        phase <= PH_FAIL;
                        err_q <= 1'b1;
                    end else if (poll_pass) begin
                        phase <= PH_XFER;
                    end
                end
                PH_FETCH: if (img_valid) begin
                    data_q <= img_data;
                    phase  <= PH_XFER;
                end
                PH_PAUSE: if (pause_done) phase <= PH_POLL;
                PH_XFER: if (spi_ack) begin
                    case (step)
                        SP_CFG_ON: begin step <= SP_QUERY; phase <= PH_POLL; end
                        SP_QUERY: begin
                            step <= SP_REPLY;
                            cnt  <= '0;
                            acc  <= '0;
                        end
                        SP_REPLY: begin
                            acc <= reply_or;
                            if (!last) begin
                                cnt <= cnt + 1'b1;
                            end else if (reply_or != 8'h00) begin
                                phase <= PH_FAIL;
                                err_q <= 1'b1;
                            end else begin
                                step  <= SP_MODE;
                                phase <= PH_POLL;
                            end
                        end
                        SP_MODE: step <= SP_MODE_ARG;
                        SP_MODE_ARG: begin
                            prog_q <= 1'b1;
                            step   <= (frames_left == '0) ? SP_CFG_OFF : SP_FRAME;
                            phase  <= PH_POLL;
                        end
                        SP_FRAME: begin
                            step  <= SP_DATA;
                            cnt   <= '0;
                            phase <= PH_FETCH;
                        end
                        SP_DATA: begin
                            if (!last) begin
                                cnt   <= cnt + 1'b1;
                                phase <= PH_FETCH;
                            end else begin
                                frames_left <= frames_left - 1'b1;
                                step  <= (frames_left == FCNT_W'(1)) ? SP_CFG_OFF : SP_FRAME;
                                phase <= PH_POLL;
                            end
                        end
                        SP_CFG_OFF: begin step <= SP_RELEASE; phase <= PH_PAUSE; end
                        default: begin
                            prog_q <= 1'b0;
                            done_q <= 1'b1;
                            phase  <= PH_DONE;
                        end
                    endcase
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign done      = done_q;
    assign err       = err_q;
    assign operating = !prog_q && (last_status == 8'h00);

endmodule

// File: rtl/spi_cfg_loader_chk.sv
module spi_cfg_loader_chk #(
    parameter int PAUSE_CYC = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       spi_req,
    input logic       spi_ack,
    input logic [7:0] spi_tx,
    input logic       spi_keep,
    input logic       poll_req,
    input logic       img_ready,
    input logic       done,
    input logic       err
);
    localparam int GW = $clog2(PAUSE_CYC + 1);

    logic [GW-1:0] gap;
    logic          data_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap          <= '0;
            data_pending <= 1'b0;
        end else begin
            if (spi_req && spi_ack) data_pending <= 1'b0;
            else if (img_ready)     data_pending <= 1'b1;
            if (spi_req && spi_ack && !data_pending && !spi_keep && spi_tx == 8'h0C)
                gap <= GW'(PAUSE_CYC);
            else if (gap != '0)
                gap <= gap - 1'b1;
        end
    end

    assert_one_channel_R10: assert property (@(posedge clk) disable iff (rst)
        !(spi_req && poll_req));
    assert_hold_request_R10: assert property (@(posedge clk) disable iff (rst)
        spi_req && !spi_ack |=> spi_req && $stable(spi_tx) && $stable(spi_keep));
    assert_silent_fail_R4: assert property (@(posedge clk) disable iff (rst)
        err |-> !spi_req && !poll_req && !img_ready);
    assert_exclusive_end_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done);
    assert_fetch_alone_R11: assert property (@(posedge clk) disable iff (rst)
        img_ready |-> !spi_req && !poll_req);
    assert_pause_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        gap != '0 |-> !poll_req);
endmodule

bind spi_cfg_loader spi_cfg_loader_chk #(.PAUSE_CYC(PAUSE_CYC)) u_chk (
    .clk(clk), .rst(rst), .start(start), .spi_req(spi_req), .spi_ack(spi_ack),
    .spi_tx(spi_tx), .spi_keep(spi_keep), .poll_req(poll_req),
    .img_ready(img_ready), .done(done), .err(err)
);

// File: tb/sim_spi_cfg_loader.sv
module sim_spi_cfg_loader;
    localparam int CLK_HZ = 2_000_000;
    localparam int PUS    = 20;
    localparam int WCYC   = 40;
    localparam int MAXP   = 8;
    localparam int LW     = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, start = 1'b0, partial_req = 1'b0;
    logic [LW-1:0] img_len = '0;
    logic img_valid, img_ready, poll_req, spi_req, spi_keep, done, err, operating;
    logic poll_ack = 1'b0, spi_ack = 1'b0;
    logic [7:0] img_data, spi_tx, poll_status = '0, spi_rx = '0;

    int checks = 0, fails = 0;
    longint cyc = 0;
    logic [8:0] exp_q[$];
    logic [7:0] reply_arr [4];
    int ptr = 0, n_img = 0, n_spi = 0, n_poll = 0, busy_left = 1, busy_pat = 0;
    int reply_left = 0, ready_miss = 0, frm_seen = 0;
    bit ready_phase = 0, stat_err_mode = 0, busy_forever = 0, prev_poll = 0, rdy_seen = 0;
    bit op_checked = 0;
    longint t_dis = -1;

    function automatic logic [7:0] img_byte(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    assign img_data  = img_byte(ptr);
    assign img_valid = (cyc % 3) != 0;

    spi_cfg_loader #(.CLK_HZ(CLK_HZ), .PAUSE_US(PUS), .MAX_POLLS(MAXP), .LEN_W(LW)) u0 (
        .clk(clk), .rst(rst), .start(start), .partial_req(partial_req), .img_len(img_len),
        .img_valid(img_valid), .img_data(img_data), .img_ready(img_ready),
        .poll_req(poll_req), .poll_ack(poll_ack), .poll_status(poll_status),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_keep(spi_keep), .spi_ack(spi_ack),
        .spi_rx(spi_rx), .done(done), .err(err), .operating(operating)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            chk(0, "WDOG", "watchdog expired", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // responder models and byte-by-byte comparison against the expected queue
    always @(negedge clk) begin
        logic [8:0] e;
        if (rdy_seen) begin ptr++; n_img++; end
        rdy_seen = img_ready && img_valid;

        if (poll_req && !prev_poll && t_dis >= 0) begin
            chk((cyc - t_dis) >= WCYC && (cyc - t_dis) <= WCYC + 3, "R7",
                "pause before release poll", cyc - t_dis, WCYC + 2);
            t_dis = -1;
        end
        prev_poll = poll_req;

        if (poll_ack) poll_ack <= 1'b0;
        else if (poll_req) begin
            n_poll++;
            if (stat_err_mode)     poll_status <= 8'h08;
            else if (busy_forever) poll_status <= 8'h01;
            else if (busy_left > 0) begin busy_left--; poll_status <= 8'h01; end
            else if (ready_phase) begin
                if (ready_miss > 0) begin ready_miss--; poll_status <= 8'h00; end
                else poll_status <= 8'h02;
            end else poll_status <= 8'h00;
            poll_ack <= 1'b1;
        end

        if (spi_ack) spi_ack <= 1'b0;
        else if (spi_req) begin
            n_spi++;
            if (exp_q.size() == 0) begin
                chk(0, "R10", "unexpected SPI request byte", spi_tx, -1);
            end else begin
                e = exp_q.pop_front();
                chk(spi_tx == e[7:0] && spi_keep == e[8], "R6", "SPI byte/keep",
                    {spi_keep, spi_tx}, e);
                if (e[7:0] == 8'hEE && e[8] && !op_checked) begin
                    op_checked = 1;
                    chk(operating == 1'b0, "R8", "operating during program mode", operating, 0);
                end
            end
            if (reply_left > 0) begin
                spi_rx <= reply_arr[4 - reply_left];
                reply_left--;
            end else spi_rx <= 8'h00;
            if (spi_tx == 8'h0B && !spi_keep) begin ready_phase = 1; ready_miss = 1; end
            if (spi_tx == 8'h01 && spi_keep && ready_phase) begin ready_phase = 0; reply_left = 4; end
            if (spi_tx == 8'hEE && spi_keep) frm_seen++;
            if (spi_tx == 8'h0C && !spi_keep) t_dis = cyc;
            if (!spi_keep) begin busy_left = busy_pat % 3; busy_pat++; end
            spi_ack <= 1'b1;
        end
    end

    task automatic q_open();
        exp_q.push_back({1'b0, 8'h0B});
        exp_q.push_back({1'b1, 8'h01});
        for (int i = 0; i < 4; i++) exp_q.push_back({i != 3, 8'h00});
    endtask

    task automatic q_rest(input int frames);
        exp_q.push_back({1'b1, 8'hAE});
        exp_q.push_back({1'b0, 8'h01});
        for (int k = 0; k < frames; k++) begin
            exp_q.push_back({1'b1, 8'hEE});
            for (int b = 0; b < 16; b++)
                exp_q.push_back({b != 15, img_byte(ptr + k * 16 + b)});
        end
        exp_q.push_back({1'b0, 8'h0C});
        exp_q.push_back({1'b0, 8'h23});
    endtask

    task automatic run(input int len, input bit part, input bit exp_err,
                       input bit inject, input string req);
        int img0;
        img0 = n_img;
        n_spi = 0; n_poll = 0;
        img_len = LW'(len); partial_req = part;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (inject) begin
            wait (frm_seen >= 1);
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int i = 0; i < 8000 && !(done || err); i++) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(err == exp_err, req, "err at end of session", err, exp_err);
        chk(done == !exp_err, "R9", "done held at end of session", done, !exp_err);
        chk(exp_q.size() == 0, req, "expected SPI bytes left over", exp_q.size(), 0);
        chk((n_img - img0) == (exp_err ? 0 : len), "R11", "image bytes consumed",
            n_img - img0, exp_err ? 0 : len);
        exp_q.delete();
    endtask

    initial begin
        foreach (reply_arr[i]) reply_arr[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && err == 0, "R9", "done/err after reset", {done, err}, 0);
        chk(spi_req == 0 && poll_req == 0 && img_ready == 0, "R10", "requests after reset",
            {spi_req, poll_req, img_ready}, 0);
        chk(operating == 1, "R8", "operating after reset", operating, 1);

        // full session, two frames, stray start in the middle (R3 R5 R6 R7 R9)
        q_open(); q_rest(2);
        run(32, 0, 0, 1, "R3");
        chk(operating == 1, "R8", "operating after release", operating, 1);

        // length not a multiple of 16 (R1)
        run(20, 0, 1, 0, "R1");
        chk(n_spi == 0 && n_poll == 0, "R1", "traffic on bad length", n_spi + n_poll, 0);

        // partial reconfiguration refused (R1)
        run(16, 1, 1, 0, "R1");
        chk(n_spi == 0 && n_poll == 0, "R1", "traffic on partial request", n_spi + n_poll, 0);

        // nonzero acknowledgement byte (R4)
        reply_arr[1] = 8'h05;
        q_open();
        run(16, 0, 1, 0, "R4");
        chk(n_spi == 6, "R4", "SPI bytes before abort", n_spi, 6);
        reply_arr[1] = 8'h00;

        // status fault bit (R2)
        stat_err_mode = 1;
        run(16, 0, 1, 0, "R2");
        chk(n_poll == 1 && n_spi == 0, "R2", "polls on status fault", n_poll, 1);
        stat_err_mode = 0;

        // device stays busy: retry limit (R2)
        busy_forever = 1;
        run(16, 0, 1, 0, "R2");
        chk(n_poll == MAXP, "R2", "polls before giving up", n_poll, MAXP);
        busy_forever = 0;

        // empty image: no frames (R6 R7)
        q_open(); q_rest(0);
        run(0, 0, 0, 0, "R6");

        // recovery after an error with one frame (R9)
        q_open(); q_rest(1);
        run(16, 0, 0, 0, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule